// File: doc/BRIEF.md
# Hardwired Step-Sequenced Control Generator

This block produces four control strobes for a small processor core from fixed gate logic rather than from a stored control word. A start strobe and a 2-bit operation code begin a run. The operation code selects one of three operations, called I1 to I3. The block latches that choice and then walks a one-hot timing register through four steps, T1 to T4, one step per clock.

In every step, each strobe is an AND-OR function of the current step bit and the latched operation bit. When the run leaves T4, the block returns to idle.

Surrounding logic issues a start and reads the strobes on `ctrl_sig` while the step runs. It can use `done` to chain the next operation. A new start may arrive in the same cycle as T4, so runs can follow each other with no idle cycle between them.

Top module: `hw_step_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes idle. In idle, `step_oh` is 0000, `ctrl_sig` is 0000 and `done` is 0.
- R2: A start with a valid operation code starts a run. The valid codes are 2'b01 for I1, 2'b10 for I2 and 2'b11 for I3. In the cycle after the start, `step_oh` is 0001 (T1).
- R3: `step_oh` bit k marks step T(k+1). Without a new start, a run moves T1→T2→T3→T4, one step per clock.
- R4: `done` is high exactly during T4. Without a new start, the cycle after T4 is idle.
- R5: During T1, every operation drives `ctrl_sig` = 0001. Bit n of `ctrl_sig` is strobe Sn.
- R6: During T2, `ctrl_sig` is 1100 for I1, 0100 for I2 and 0110 for I3.
- R7: During T3, `ctrl_sig` is 0010 for I1, 1000 for I2 and 1010 for I3.
- R8: During T4, `ctrl_sig` is 0001 for I1, 1100 for I2 and 0101 for I3.
- R9: While idle, `ctrl_sig` is 0000.
- R10: A start with code 2'b00 has no effect. An idle block stays idle, and a running block keeps its operation and its step order.
- R11: A valid start during any step, T4 included, restarts at T1 on the next cycle with the new operation.
- R12: Without a valid start, the latched operation holds for the whole run. A change on `op_code` alone has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start strobe, sampled at the clock edge |
| op_code | input | 2 | Operation select: 01 = I1, 10 = I2, 11 = I3, 00 = invalid |
| ctrl_sig | output | 4 | Control strobes S3..S0 |
| step_oh | output | 4 | One-hot current step, bit 0 = T1 |
| done | output | 1 | High during the last step |

## Verification
The strobes depend only on the two internal registers, so any fault in either one shows at the ports in the same cycle. A dropped or doubled step bit breaks the one-hot pattern on `step_oh`. A wrong latched operation gives a wrong strobe pattern no later than T2, because T1 is identical for all operations. A counter that fails to clear shows as strobes in a cycle that should be idle, or as a `done` pulse at the wrong time. For these reasons, every cycle is compared against a reference table on all three outputs.

// File: rtl/hw_step_ctrl_pkg.sv
package hw_step_ctrl_pkg;
  localparam int NUM_OPS   = 3;
  localparam int NUM_STEPS = 4;
  localparam int NUM_SIGS  = 4;
  localparam int CODE_W    = 2;

  typedef logic [NUM_OPS-1:0]   op_oh_t;
  typedef logic [NUM_STEPS-1:0] step_oh_t;
  typedef logic [NUM_SIGS-1:0]  sig_vec_t;

  // Code 0 is reserved; codes 1..NUM_OPS select an operation.
  function automatic logic code_is_valid(input logic [CODE_W-1:0] code);
    return (code != '0) && (int'(code) <= NUM_OPS);
  endfunction

  function automatic op_oh_t code_to_onehot(input logic [CODE_W-1:0] code);
    op_oh_t r;
    r = '0;
    for (int k = 0; k < NUM_OPS; k++)
      if (int'(code) == k + 1) r[k] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/hw_step_seq.sv
module hw_step_seq
  import hw_step_ctrl_pkg::*;
#(
  parameter int STEPS = NUM_STEPS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  output logic [STEPS-1:0] step,
  output logic             last_step
);
  localparam logic [STEPS-1:0] FIRST = {{(STEPS-1){1'b0}}, 1'b1};

  // One-hot timing register; the last bit shifts out and leaves it idle.
  always_ff @(posedge clk) begin
    if (rst)       step <= '0;
    else if (load) step <= FIRST;
    else           step <= step << 1;
  end

  assign last_step = step[STEPS-1];
endmodule

// File: rtl/hw_op_latch.sv
module hw_op_latch
  import hw_step_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  output op_oh_t            op
);
  always_ff @(posedge clk) begin
    if (rst)       op <= '0;
    else if (load) op <= code_to_onehot(code);
  end
endmodule

// File: rtl/hw_sig_matrix.sv
module hw_sig_matrix
  import hw_step_ctrl_pkg::*;
(
  input  step_oh_t step,
  input  op_oh_t   op,
  output sig_vec_t sig
);
  logic t1, t2, t3, t4;
  logic i1, i2, i3;

  assign {t4, t3, t2, t1} = step;
  assign {i3, i2, i1}     = op;

  // Sum-of-products per strobe, reduced from the step/operation table.
  assign sig[0] = t1 | (t4 & (i1 | i3));
  assign sig[1] = (t2 & i3) | (t3 & (i1 | i3));
  assign sig[2] = (t2 & (i1 | i2 | i3)) | (t4 & (i2 | i3));
  assign sig[3] = (t2 & i1) | (t3 & (i2 | i3)) | (t4 & i2);
endmodule

// File: rtl/hw_step_ctrl.sv
module hw_step_ctrl
  import hw_step_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CODE_W-1:0] op_code,
  output logic [NUM_SIGS-1:0]  ctrl_sig,
  output logic [NUM_STEPS-1:0] step_oh,
  output logic              done
);
  logic   run_load;
  op_oh_t op_q;

  assign run_load = start & code_is_valid(op_code);

  hw_step_seq #(.STEPS(NUM_STEPS)) u_seq (
    .clk(clk), .rst(rst), .load(run_load), .step(step_oh), .last_step(done)
  );

  hw_op_latch u_op (
    .clk(clk), .rst(rst), .load(run_load), .code(op_code), .op(op_q)
  );

  hw_sig_matrix u_mat (
    .step(step_oh), .op(op_q), .sig(ctrl_sig)
  );

  a_r3_onehot_step: assert property (@(posedge clk) disable iff (rst)
    $onehot0(step_oh));
  a_r2_start_enters_t1: assert property (@(posedge clk) disable iff (rst)
    (start && op_code != 2'b00) |=> (step_oh == 4'b0001));
  a_r3_advance: assert property (@(posedge clk) disable iff (rst)
    ((|step_oh[NUM_STEPS-2:0]) && !start) |=> (step_oh == ($past(step_oh) << 1)));
  a_r4_done_last: assert property (@(posedge clk) disable iff (rst)
    done |-> (step_oh == 4'b1000));
  a_r5_t1_only_s0: assert property (@(posedge clk) disable iff (rst)
    step_oh[0] |-> (ctrl_sig == 4'b0001));
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (step_oh == '0) |-> (ctrl_sig == '0 && !done));
  a_r10_bad_code_idle: assert property (@(posedge clk) disable iff (rst)
    (start && op_code == 2'b00 && step_oh == '0) |=> (step_oh == '0));
  a_r12_op_held: assert property (@(posedge clk) disable iff (rst)
    ((|step_oh[NUM_STEPS-2:0]) && !run_load) |=> $stable(op_q));
endmodule

// File: tb/hw_step_ctrl_bench.sv
module hw_step_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [1:0] op_code = 2'b00;
  logic [3:0] ctrl_sig;
  logic [3:0] step_oh;
  logic       done;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  hw_step_ctrl u_hw_step_ctrl (
    .clk(clk), .rst(rst), .start(start), .op_code(op_code),
    .ctrl_sig(ctrl_sig), .step_oh(step_oh), .done(done)
  );

  // Reference table, {S3,S2,S1,S0} per operation (row) and step (column).
  localparam logic [3:0] TBL [0:2][0:3] = '{
    '{4'b0001, 4'b1100, 4'b0010, 4'b0001},
    '{4'b0001, 4'b0100, 4'b1000, 4'b1100},
    '{4'b0001, 4'b0110, 4'b1010, 4'b0101}
  };

  typedef struct {
    logic [3:0] step;
    logic [3:0] sig;
    logic       dn;
    int         stepno;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int m_step = 0;   // 0 = idle, 1..4 = T1..T4
  int m_op   = 1;   // 1..3

  task automatic check(input bit ok, input string req, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%b exp=%b", req, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus, steps the model, queues the result.
  task automatic tick(input logic st, input logic [1:0] cd, input string tg);
    exp_t e;
    start = st;
    op_code = cd;
    if (st && cd != 2'b00) begin
      m_step = 1;
      m_op = int'(cd);
    end else if (m_step >= 1 && m_step <= 3) m_step++;
    else m_step = 0;
    @(posedge clk);
    e.stepno = m_step;
    e.step = (m_step == 0) ? 4'b0000 : (4'b0001 << (m_step - 1));
    e.sig  = (m_step == 0) ? 4'b0000 : TBL[m_op-1][m_step-1];
    e.dn   = (m_step == 4);
    e.tag  = tg;
    exp_q.push_back(e);
    #1;
  endtask

  // Monitor: compares outputs in the middle of each cycle.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      string rq;
      e = exp_q.pop_front();
      case (e.stepno)
        1: rq = "R5";
        2: rq = "R6";
        3: rq = "R7";
        4: rq = "R8";
        default: rq = "R9";
      endcase
      check(step_oh == e.step, {e.tag, "/R3"}, "step_oh", step_oh, e.step);
      check(ctrl_sig == e.sig, {e.tag, "/", rq}, "ctrl_sig", ctrl_sig, e.sig);
      check(done == e.dn, {e.tag, "/R4"}, "done", {3'b000, done}, {3'b000, e.dn});
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(step_oh == 4'b0000 && ctrl_sig == 4'b0000 && !done, "R1", "reset outs",
          {step_oh[2:0], done}, 4'b0000);
    @(posedge clk);
    #1 rst = 1'b0;

    // R2..R9: each operation through all steps, then idle
    for (int c = 1; c <= 3; c++) begin
      tick(1'b1, 2'(c), "R2");
      repeat (3) tick(1'b0, 2'b00, "R3");
      tick(1'b0, 2'b00, "R9");
    end

    // R10: reserved code is ignored, idle and mid-run
    tick(1'b1, 2'b00, "R10");
    tick(1'b1, 2'b01, "R2");
    tick(1'b1, 2'b00, "R10");
    tick(1'b1, 2'b00, "R10");
    tick(1'b0, 2'b00, "R10");
    tick(1'b0, 2'b00, "R10");

    // R11: back-to-back at T4 and restart mid-run
    tick(1'b1, 2'b10, "R11");
    tick(1'b0, 2'b00, "R11");
    tick(1'b0, 2'b00, "R11");
    tick(1'b0, 2'b00, "R11");
    tick(1'b1, 2'b11, "R11");
    tick(1'b0, 2'b00, "R11");
    tick(1'b1, 2'b01, "R11");
    repeat (4) tick(1'b0, 2'b00, "R11");

    // R12: code changes without start do nothing
    tick(1'b1, 2'b11, "R12");
    tick(1'b0, 2'b01, "R12");
    tick(1'b0, 2'b10, "R12");
    tick(1'b0, 2'b01, "R12");
    tick(1'b0, 2'b10, "R12");

    @(negedge clk);
    #1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule